// File: doc/BRIEF.md
# Seed-Advancing Stochastic Number Generator

This block turns an unsigned fixed-point fraction into a unipolar stochastic bit stream. On every enabled cycle it compares the fraction with the state of a maximal-length Galois LFSR of the same width. The result of that comparison becomes one serial bit, so over a run of steps the share of ones tracks the fraction.

A fixed-seed generator always gives the same pattern for the same input. This one does not. It counts LFSR steps, and once a complete LFSR period has gone by it raises a one-cycle pulse, bumps its stored seed by one and restarts the LFSR from that new seed. An iterated chaotic loop that feeds the same value back twice therefore gets two different streams, which adds a small perturbation to the loop.

The fraction is captured on the first step of each period and held until the period ends. Stream decoding and stream arithmetic are left to neighbouring blocks.

Top module: `sngSeedStep`

## Requirements
- R1: While `rstN` is low at a clock edge, `streamBit` and `periodDone` are 0 after that edge. The stored seed and the LFSR are loaded from `seedInit`.
- R2: On each edge where `en` is high, `streamBit` takes the value 1 if the LFSR state before the edge is strictly below the held fraction, and 0 otherwise. The LFSR then advances one Galois step: shift right by one bit, and if the bit shifted out was 1, XOR the result with `TAPS`.
- R3: On an edge where `en` is low, the LFSR, the step count and `streamBit` keep their values and `periodDone` is 0.
- R4: The fraction is sampled from `valueIn` on the first enabled step of each period and used for all 2^WIDTH-1 steps of that period. Changes of `valueIn` later in the period have no effect.
- R5: After exactly 2^WIDTH-1 enabled steps since reset or since the previous period end, `periodDone` is 1 for one cycle. It appears after the same edge that produces the period's last stream bit.
- R6: At each period end the stored seed increases by one, and the next period's LFSR sequence starts from that new seed.
- R7: A seed value of zero is never used. A zero `seedInit` is replaced by 1, and an increment that wraps the all-ones seed to zero gives 1 instead.
- R8: Over one full period with held fraction V, the number of ones in the stream is V-1 for V at least 1, and 0 for V equal to 0.
- R9: Two consecutive periods with the same held fraction produce different bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; loads the seed |
| en | input | 1 | Step enable for the LFSR and stream |
| valueIn | input | WIDTH | Unsigned fraction to encode |
| seedInit | input | WIDTH | Seed loaded during reset |
| streamBit | output | 1 | Registered stochastic stream bit |
| periodDone | output | 1 | One-cycle pulse at the end of each LFSR period |

## Verification
Every result of this block is due one edge after the enabled step that causes it. A stream bit shows the comparison made at that edge. The period pulse follows the 2^WIDTH-1st step on the same edge, and the next period's first bit follows the step right after it. The bench's behavioural model advances on the same edge as the design, and the bench compares the model with the design on the following falling edge, before it drives new inputs.

Per-period counts of ones, and the difference between the patterns of back-to-back periods, are totalled over the bits that follow enabled steps. They are judged at the cycle of the period pulse. New fractions are applied on that falling edge, so that the next step samples them.

// File: rtl/sngSeedPkg.sv
package sngSeedPkg;

  // Strobes from the step counter to the datapath
  typedef struct packed {
    logic stepEn;       // advance LFSR and emit a bit
    logic periodStart;  // first step of a period: sample the fraction
    logic periodEnd;    // last step of a period: reseed
  } sngStrobes_t;

endpackage

// File: rtl/sngSeedCtrl.sv
module sngSeedCtrl #(
  parameter int WIDTH = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      en,
  output sngSeedPkg::sngStrobes_t   ctl
);
  localparam logic [WIDTH-1:0] LAST_STEP = {{(WIDTH-1){1'b1}}, 1'b0}; // 2^W-2

  logic [WIDTH-1:0] stepCnt;

  always_comb begin
    ctl.stepEn      = en;
    ctl.periodStart = en && (stepCnt == '0);
    ctl.periodEnd   = en && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (en) begin
      if (stepCnt == LAST_STEP) stepCnt <= '0;
      else                      stepCnt <= stepCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sngSeedPath.sv
module sngSeedPath #(
  parameter int              WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sngSeedPkg::sngStrobes_t   ctl,
  input  logic [WIDTH-1:0]          valueIn,
  input  logic [WIDTH-1:0]          seedInit,
  output logic                      streamBit,
  output logic                      periodDone
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] lfsrQ;
  logic [WIDTH-1:0] seedQ;
  logic [WIDTH-1:0] heldQ;
  logic [WIDTH-1:0] lfsrStep;
  logic [WIDTH-1:0] seedBump;
  logic [WIDTH-1:0] seedBoot;
  logic [WIDTH-1:0] cmpVal;

  // Galois step, right shift
  always_comb begin
    lfsrStep = lfsrQ >> 1;
    if (lfsrQ[0]) lfsrStep = lfsrStep ^ TAPS;
  end

  // Seeds that would be zero become one
  always_comb begin
    seedBump = seedQ + ONE;
    if (seedBump == '0) seedBump = ONE;
    seedBoot = (seedInit == '0) ? ONE : seedInit;
  end

  assign cmpVal = ctl.periodStart ? valueIn : heldQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ      <= seedBoot;
      seedQ      <= seedBoot;
      heldQ      <= '0;
      streamBit  <= 1'b0;
      periodDone <= 1'b0;
    end else begin
      periodDone <= ctl.periodEnd;
      if (ctl.stepEn) begin
        streamBit <= (lfsrQ < cmpVal);
        if (ctl.periodStart) heldQ <= valueIn;
        if (ctl.periodEnd) begin
          seedQ <= seedBump;
          lfsrQ <= seedBump;
        end else begin
          lfsrQ <= lfsrStep;
        end
      end
    end
  end
endmodule

// File: rtl/sngSeedStep.sv
module sngSeedStep #(
  parameter int               WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS  = 16'hB400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [WIDTH-1:0] valueIn,
  input  logic [WIDTH-1:0] seedInit,
  output logic             streamBit,
  output logic             periodDone
);
  sngSeedPkg::sngStrobes_t ctl;

  sngSeedCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .en   (en),
    .ctl  (ctl)
  );

  sngSeedPath #(.WIDTH(WIDTH), .TAPS(TAPS)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .valueIn    (valueIn),
    .seedInit   (seedInit),
    .streamBit  (streamBit),
    .periodDone (periodDone)
  );
endmodule

// File: rtl/sngSeedStepChk.sv
module sngSeedStepChk #(
  parameter int WIDTH = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    en,
  input logic [WIDTH-1:0]        valueIn,
  input logic                    streamBit,
  input logic                    periodDone,
  input sngSeedPkg::sngStrobes_t ctl
);
  // R5: the pulse lasts one cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    periodDone |=> !periodDone);

  // R5: the last counted step yields the pulse on the next cycle
  p_done_after_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.periodEnd |=> periodDone);

  // R3: an idle cycle changes nothing visible
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(streamBit) && !periodDone));

  // R4: the step after a period end is a fresh sample point
  p_start_after_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (periodDone && en) |-> ctl.periodStart);

  // R8: a zero fraction never yields a one on a sampling step
  p_zero_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.periodStart && valueIn == '0) |=> !streamBit);
endmodule

bind sngSeedStep sngSeedStepChk #(.WIDTH(WIDTH)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .en         (en),
  .valueIn    (valueIn),
  .streamBit  (streamBit),
  .periodDone (periodDone),
  .ctl        (ctl)
);

// File: tb/sngSeedStep_test.sv
module sngSeedStep_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst0N, rst1N, en0, en1;
  logic [15:0] val0, seed0;
  logic [7:0]  val1, seed1;
  logic str0, done0, str1, done1;

  sngSeedStep uut (
    .clk(clk), .rstN(rst0N), .en(en0), .valueIn(val0), .seedInit(seed0),
    .streamBit(str0), .periodDone(done0));

  sngSeedStep #(.WIDTH(8), .TAPS(8'hB8)) uutSmall (
    .clk(clk), .rstN(rst1N), .en(en1), .valueIn(val1), .seedInit(seed1),
    .streamBit(str1), .periodDone(done1));

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, one slot per instance
  int  mLfsr[2], mSeed[2], mHeld[2], mCnt[2];
  bit  mBit[2], mDone[2];

  function automatic int galois(input int s, input int taps);
    return (s >> 1) ^ (((s & 1) != 0) ? taps : 0);
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int w, mask, taps, v, sd, cmp;
      bit r, e;
      w    = (k == 1) ? 8 : 16;
      mask = (1 << w) - 1;
      taps = (k == 1) ? 'hB8 : 'hB400;
      r    = (k == 1) ? rst1N : rst0N;
      e    = (k == 1) ? en1 : en0;
      v    = (k == 1) ? int'(val1) : int'(val0);
      sd   = (k == 1) ? int'(seed1) : int'(seed0);
      if (!r) begin
        mSeed[k] = (sd == 0) ? 1 : sd;
        mLfsr[k] = mSeed[k];
        mHeld[k] = 0; mCnt[k] = 0; mBit[k] = 0; mDone[k] = 0;
      end else begin
        mDone[k] = 0;
        if (e) begin
          cmp = (mCnt[k] == 0) ? v : mHeld[k];
          if (mCnt[k] == 0) mHeld[k] = v;
          mBit[k] = (mLfsr[k] < cmp);
          if (mCnt[k] == mask - 1) begin
            mDone[k] = 1;
            mSeed[k] = (mSeed[k] + 1) & mask;
            if (mSeed[k] == 0) mSeed[k] = 1;
            mLfsr[k] = mSeed[k];
            mCnt[k]  = 0;
          end else begin
            mLfsr[k] = galois(mLfsr[k], taps);
            mCnt[k]++;
          end
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      check(0, "watchdog", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tag0, tag1;
    bit prevEn0, prevEn1;
    int ones0, ones1, done0Cnt, p1, stopAt, rstHold, smallPhase;
    logic [254:0] bits1, prevBits1;
    rst0N = 0; rst1N = 0; en0 = 0; en1 = 0;
    val0 = 16'h4000; seed0 = 16'hACE1; val1 = 8'h80; seed1 = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(str0 == 1'b0, "R1 stream0", str0, 0);
    check(done0 == 1'b0, "R1 done0", done0, 0);
    check(str1 == 1'b0, "R1 stream1", str1, 0);
    check(done1 == 1'b0, "R1 done1", done1, 0);
    rst0N = 1; rst1N = 1;
    tag0 = "R2"; tag1 = "R2"; prevEn0 = 0; prevEn1 = 0;
    ones0 = 0; ones1 = 0; done0Cnt = 0; p1 = 0; stopAt = 0; rstHold = 0;
    smallPhase = 0; bits1 = '0; prevBits1 = '0;
    for (int c = 0; !(done0Cnt >= 1 && c >= stopAt); c++) begin
      @(negedge clk);
      // Per-cycle comparison with the model
      check(str0 === mBit[0], tag0, str0, mBit[0]);
      check(done0 === mDone[0], "R5 done0", done0, mDone[0]);
      check(str1 === mBit[1], tag1, str1, mBit[1]);
      check(done1 === mDone[1], "R5 done1", done1, mDone[1]);
      // Large instance period statistics
      if (prevEn0) ones0 += str0;
      if (done0) begin
        check(ones0 == 16'h3FFF, "R8 ones per period (16-bit)", ones0, 16'h3FFF);
        done0Cnt++;
        ones0 = 0;
        stopAt = c + 300;
      end
      // Small instance period statistics
      if (prevEn1) begin
        ones1 += str1;
        bits1 = {bits1[253:0], str1};
      end
      if (done1) begin
        int expOnes;
        expOnes = (val1 == 0) ? 0 : int'(val1) - 1;
        check(ones1 == expOnes, "R8 ones per period (8-bit)", ones1, expOnes);
        if (smallPhase == 0 && p1 == 1)
          check(bits1 != prevBits1, "R9 repeated value gives new pattern", 1, 0);
        prevBits1 = bits1;
        ones1 = 0;
        p1++;
        case (p1)
          1: val1 = 8'h80;
          2: val1 = 8'h00;
          3: val1 = 8'hFF;
          default: val1 = 8'h80;
        endcase
        if (smallPhase == 0 && p1 == 5) begin
          rst1N = 0; seed1 = 8'hFE; rstHold = 2; smallPhase = 1; p1 = 10;
        end
      end
      if (rstHold > 0) begin
        rstHold--;
        if (rstHold == 0) rst1N = 1;
      end
      // Large instance stimulus
      en0  = !((c % 7) == 3 && c < 3000);
      val0 = (c < 500) ? 16'h4000 : 16'h9000;
      if (done0Cnt >= 1)              tag0 = "R6 reseeded stream";
      else if (!en0)                  tag0 = "R3 idle hold";
      else if (c >= 500 && c < 3000)  tag0 = "R4 late value ignored";
      else                            tag0 = "R2 stream";
      // Small instance stimulus
      en1  = 1'b1;
      tag1 = (smallPhase == 1) ? "R7 seed wrap stream" : "R2 small stream";
      prevEn0 = en0 && rst0N;
      prevEn1 = en1 && rst1N;
    end
    check(p1 >= 13, "R7 periods after wrap", p1, 13);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule